// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This block sits beside a bus master and turns each bus cycle into a set of active-low select strobes plus a cycle-completion signal. It holds one control register per address window: an upper memory window (open towards the top of memory), a lower memory window (open from address zero), a mid-range memory window, and a parameterised number of peripheral windows. Each peripheral window can be placed in either memory space or I/O space. Every register carries the window bounds in 1 KiB granules, a two-bit wait count and a flag that makes the cycle wait for an external ready.

A cycle is presented with a one-clock `cyc_start` strobe, together with the address, the cycle type and the initiator. The unit compares the address with every enabled window in the same clock. It then holds the matching selects low for the length of the cycle. The cycle length comes from the merged timing of all matching windows: the largest wait count wins, and a single window that needs ready makes the whole cycle wait for it. A window becomes enabled the first time its register is read or written, and it stays enabled until reset.

The sequencer has three named states. `S_IDLE` waits for a start. `S_COUNT` burns the programmed wait cycles. `S_READY` is the final cycle, which ends when ready is not needed or is sampled high. The transitions are: `S_IDLE→S_COUNT` on a start with merged waits above zero; `S_IDLE→S_READY` on a start with zero merged waits; `S_COUNT→S_READY` when the counter reaches its last wait; `S_COUNT→S_COUNT` otherwise; `S_READY→S_IDLE` on completion; `S_READY→S_READY` while ready is needed and low.

Top module: `chip_select_unit`

## Requirements
- R1: After reset every `sel_n` bit is high, `cyc_done` is low and only window 0 (upper) is enabled. Window 0 resets to base 0x3FF, limit 0, I/O bit 0, ready-needed 1 and 3 waits. All other windows reset to all-zero fields.
- R2: Register layout, with window index `reg_addr` (0 upper, 1 lower, 2 mid, 3 and up peripheral): bits [1:0] wait count, bit [2] ready-needed, bit [3] I/O space, bits [13:4] base granule, bits [23:14] limit granule. `reg_rdata` shows the addressed register combinationally, with the enable in bit [24]. A write on `reg_wr` updates all fields.
- R3: A read strobe (`reg_rd`) or a write strobe on a window enables it from the next clock. A read-only enable leaves the fields at their reset values.
- R4: An enabled window stays enabled. Later writes change its fields but never clear the enable.
- R5: The upper, lower and mid windows match only memory cycles. `cyc_type` codes are 0 memory read, 1 memory write, 2 instruction fetch, 3 I/O read, 4 I/O write; codes 5 to 7 match no window.
- R6: A peripheral window with the I/O bit set matches only types 3 and 4. With the bit clear, it matches only types 0 to 2.
- R7: Initiator codes 0 (CPU), 1 (DMA) and 2 (refresh) can all produce selects. Code 3 matches no window.
- R8: Address granule g = `cyc_addr[19:10]`. The upper window matches g ≥ base, the lower window matches g ≤ limit, and the mid and peripheral windows match base ≤ g ≤ limit.
- R9: A start accepted at a clock edge drives the matching selects low from the next cycle through the cycle in which `cyc_done` is high. `cyc_done` is a single-cycle pulse, and all selects return high in the cycle after it. With merged wait count w and ready not needed, `cyc_done` is high w+1 cycles after the accepting edge.
- R10: When windows overlap, the cycle uses the largest wait count among the matching windows.
- R11: If any matching window needs ready, `cyc_done` waits for the later of the wait count expiring and `rdy` being high, even when the other windows ignore ready.
- R12: A cycle that matches no window asserts no select, ignores `rdy` and completes one cycle after the accepting edge.
- R13: `cyc_start` is ignored while a cycle is in progress.
- R14: A peripheral window in I/O space may cover the coprocessor-reserved I/O bytes 0x00F8 to 0x00FF and selects there like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Window register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables the window) |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 25 | Addressed register with the enable in the top bit |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_addr | input | 20 | Bus cycle address |
| cyc_type | input | 3 | Bus cycle type code |
| cyc_src | input | 2 | Cycle initiator code |
| rdy | input | 1 | External bus ready |
| sel_n | output | 7 | Active-low window selects |
| cyc_done | output | 1 | Cycle completion pulse |

## Verification
A wrong internal state shows at the ports within one cycle of the start edge. A stuck sequencer leaves selects low past the completion pulse, or it never raises `cyc_done`. A wrong wait merge or a dropped ready requirement moves the completion pulse by one or more cycles, and the bench measures that exactly against the overlap cases. A lost enable or a bad range compare shows up as a wrong select mask in the first cycle after the start. The register readback also exposes any enable bit that has been cleared.

// File: rtl/cs_pkg.sv
package cs_pkg;

    parameter int unsigned ADDR_W     = 20;
    parameter int unsigned GRAN_SHIFT = 10;
    localparam int unsigned FIELD_W   = ADDR_W - GRAN_SHIFT;
    localparam int unsigned WS_W      = 2;
    localparam int unsigned REG_W     = 2 * FIELD_W + WS_W + 2;

    localparam logic [2:0] CT_MEM_RD = 3'd0;
    localparam logic [2:0] CT_MEM_WR = 3'd1;
    localparam logic [2:0] CT_FETCH  = 3'd2;
    localparam logic [2:0] CT_IO_RD  = 3'd3;
    localparam logic [2:0] CT_IO_WR  = 3'd4;

    localparam logic [1:0] SRC_NONE  = 2'd3;

    typedef enum logic [1:0] {
        WK_UPPER,
        WK_LOWER,
        WK_MID,
        WK_PERIPH
    } win_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] limit;
        logic [FIELD_W-1:0] base;
        logic               io_space;
        logic               need_rdy;
        logic [WS_W-1:0]    waits;
    } win_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COUNT,
        S_READY
    } seq_state_e;

endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
    import cs_pkg::*;
#(
    parameter int unsigned NWIN  = 7,
    parameter int unsigned IDX_W = $clog2(NWIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       reg_addr,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W:0]         reg_rdata,
    output win_cfg_t [NWIN-1:0]    cfg_q,
    output logic [NWIN-1:0]        en_q
);

    localparam win_cfg_t UPPER_RST = '{
        limit:    '0,
        base:     '1,
        io_space: 1'b0,
        need_rdy: 1'b1,
        waits:    '1
    };

    logic addr_valid;
    assign addr_valid = 32'(reg_addr) < NWIN;

    // Window registers; the enable only ever sets outside reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWIN; i++) begin
                cfg_q[i] <= (i == 0) ? UPPER_RST : '0;
                en_q[i]  <= (i == 0);
            end
        end else begin
            for (int i = 0; i < NWIN; i++) begin
                if (reg_addr == IDX_W'(i)) begin
                    if (reg_wr) begin
                        cfg_q[i] <= win_cfg_t'(reg_wdata);
                    end
                    if (reg_wr || reg_rd) begin
                        en_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (addr_valid) begin
            reg_rdata = {en_q[reg_addr], cfg_q[reg_addr]};
        end
    end

endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
    import cs_pkg::*;
#(
    parameter win_kind_e KIND = WK_MID
) (
    input  logic               en,
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] limit,
    input  logic               io_space,
    input  logic [FIELD_W-1:0] gran,
    input  logic [2:0]         cyc_type,
    input  logic [1:0]         cyc_src,
    output logic               hit
);

    // Which side of the window is open depends on its kind
    localparam logic LO_OPEN   = (KIND == WK_LOWER);
    localparam logic HI_OPEN   = (KIND == WK_UPPER);
    localparam logic IS_PERIPH = (KIND == WK_PERIPH);

    logic mem_cyc, io_cyc, src_ok, lo_ok, hi_ok, space_ok;

    always_comb begin
        mem_cyc  = (cyc_type == CT_MEM_RD) || (cyc_type == CT_MEM_WR) ||
                   (cyc_type == CT_FETCH);
        io_cyc   = (cyc_type == CT_IO_RD) || (cyc_type == CT_IO_WR);
        src_ok   = (cyc_src != SRC_NONE);
        lo_ok    = LO_OPEN | (gran >= base);
        hi_ok    = HI_OPEN | (gran <= limit);
        space_ok = (IS_PERIPH & io_space) ? io_cyc : mem_cyc;
        hit      = en & src_ok & space_ok & lo_ok & hi_ok;
    end

endmodule

// File: rtl/cs_merge.sv
module cs_merge
    import cs_pkg::*;
#(
    parameter int unsigned NWIN = 7
) (
    input  logic [NWIN-1:0]           hit,
    input  logic [NWIN-1:0][WS_W-1:0] waits,
    input  logic [NWIN-1:0]           need_rdy,
    output logic [WS_W-1:0]           ws_max,
    output logic                      rdy_any
);

    // Largest wait count and OR of ready demands over matching windows
    always_comb begin
        ws_max  = '0;
        rdy_any = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            if (hit[i]) begin
                if (waits[i] > ws_max) begin
                    ws_max = waits[i];
                end
                rdy_any = rdy_any | need_rdy[i];
            end
        end
    end

endmodule

// File: rtl/cs_seq.sv
module cs_seq
    import cs_pkg::*;
#(
    parameter int unsigned NWIN = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic [NWIN-1:0] hit,
    input  logic [WS_W-1:0] ws,
    input  logic            need_rdy,
    input  logic            rdy,
    output logic [NWIN-1:0] sel_n,
    output logic            cyc_done,
    output logic            busy,
    output logic            need_q
);

    seq_state_e      state, state_nx;
    logic [WS_W-1:0] cnt;
    logic [NWIN-1:0] hit_q;

    // State register with the per-cycle capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            hit_q  <= '0;
            need_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && cyc_start) begin
                hit_q  <= hit;
                need_q <= need_rdy;
                cnt    <= ws;
            end else if (state == S_COUNT) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (cyc_start) begin
                    state_nx = (ws != '0) ? S_COUNT : S_READY;
                end
            end
            S_COUNT: begin
                if (cnt == WS_W'(1)) begin
                    state_nx = S_READY;
                end
            end
            S_READY: begin
                if (!need_q || rdy) begin
                    state_nx = S_IDLE;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        cyc_done = 1'b0;
        sel_n    = '1;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_COUNT: begin
                busy  = 1'b1;
                sel_n = ~hit_q;
            end
            S_READY: begin
                busy     = 1'b1;
                sel_n    = ~hit_q;
                cyc_done = !need_q || rdy;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
    import cs_pkg::*;
#(
    parameter  int unsigned NUM_PERIPH = 4,
    localparam int unsigned NWIN       = 3 + NUM_PERIPH,
    localparam int unsigned IDX_W      = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W:0]    reg_rdata,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [2:0]        cyc_type,
    input  logic [1:0]        cyc_src,
    input  logic              rdy,
    output logic [NWIN-1:0]   sel_n,
    output logic              cyc_done
);

    win_cfg_t [NWIN-1:0]      cfg_q;
    logic [NWIN-1:0]          en_q;
    logic [NWIN-1:0]          hit;
    logic [NWIN-1:0][WS_W-1:0] win_waits;
    logic [NWIN-1:0]          win_rdy;
    logic [WS_W-1:0]          ws_max;
    logic                     rdy_any;
    logic                     busy;
    logic                     need_q;
    logic [FIELD_W-1:0]       gran;
    logic [GRAN_SHIFT-1:0]    addr_unused_bits;

    assign gran             = cyc_addr[ADDR_W-1:GRAN_SHIFT];
    assign addr_unused_bits = cyc_addr[GRAN_SHIFT-1:0];

    cs_regfile #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_q     (cfg_q),
        .en_q      (en_q)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam win_kind_e KIND = (i == 0) ? WK_UPPER :
                                     (i == 1) ? WK_LOWER :
                                     (i == 2) ? WK_MID   : WK_PERIPH;

        assign win_waits[i] = cfg_q[i].waits;
        assign win_rdy[i]   = cfg_q[i].need_rdy;

        cs_window_match #(.KIND(KIND)) u_match (
            .en       (en_q[i]),
            .base     (cfg_q[i].base),
            .limit    (cfg_q[i].limit),
            .io_space (cfg_q[i].io_space),
            .gran     (gran),
            .cyc_type (cyc_type),
            .cyc_src  (cyc_src),
            .hit      (hit[i])
        );
    end

    cs_merge #(.NWIN(NWIN)) u_merge (
        .hit      (hit),
        .waits    (win_waits),
        .need_rdy (win_rdy),
        .ws_max   (ws_max),
        .rdy_any  (rdy_any)
    );

    cs_seq #(.NWIN(NWIN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .hit       (hit),
        .ws        (ws_max),
        .need_rdy  (rdy_any),
        .rdy       (rdy),
        .sel_n     (sel_n),
        .cyc_done  (cyc_done),
        .busy      (busy),
        .need_q    (need_q)
    );

endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int unsigned NWIN  = 7,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NWIN-1:0]  sel_n,
    input logic             cyc_done,
    input logic             rdy,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [IDX_W-1:0] reg_addr,
    input logic [NWIN-1:0]  en_q,
    input logic             busy,
    input logic             need_q
);

    assert_idle_sel_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&sel_n));

    assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (&sel_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    assert_access_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && (32'(reg_addr) < NWIN)) |=> en_q[$past(reg_addr)]);

    assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & $past(en_q)) == $past(en_q));

    assert_ready_gates_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && need_q) |-> rdy);

endmodule

bind chip_select_unit cs_checker #(.NWIN(NWIN), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .cyc_done (cyc_done),
    .rdy      (rdy),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .en_q     (en_q),
    .busy     (busy),
    .need_q   (need_q)
);

// File: tb/chip_select_unit_bench.sv
`timescale 1ns/1ps
module chip_select_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [24:0] reg_rdata;
    logic        cyc_start = 1'b0;
    logic [19:0] cyc_addr = '0;
    logic [2:0]  cyc_type = '0;
    logic [1:0]  cyc_src = '0;
    logic        rdy = 1'b0;
    logic [6:0]  sel_n;
    logic        cyc_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    chip_select_unit u_chip_select_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cyc_start (cyc_start),
        .cyc_addr  (cyc_addr),
        .cyc_type  (cyc_type),
        .cyc_src   (cyc_src),
        .rdy       (rdy),
        .sel_n     (sel_n),
        .cyc_done  (cyc_done)
    );

    typedef struct packed {
        logic [19:0] addr;
        logic [2:0]  ctype;
        logic [1:0]  src;
        logic [3:0]  rdy_at;
        logic [6:0]  exp_sel;
        logic [3:0]  exp_lat;
    } vec_t;

    // addr, type, source, ready-rise cycle, expected active selects, latency
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{20'hFC010, 3'd0, 2'd0, 4'd9, 7'h01, 4'd1},  // R8 upper
        '{20'h02000, 3'd1, 2'd1, 4'd9, 7'h02, 4'd2},  // R7 DMA, lower
        '{20'h40000, 3'd2, 2'd0, 4'd9, 7'h04, 4'd3},  // R5 fetch, mid
        '{20'h60010, 3'd0, 2'd2, 4'd9, 7'h0C, 4'd4},  // R10 mid+per0 -> 3 waits
        '{20'h7C000, 3'd0, 2'd0, 4'd2, 7'h14, 4'd3},  // R11 ready early
        '{20'h7C000, 3'd1, 2'd0, 4'd6, 7'h14, 4'd6},  // R11 ready late
        '{20'h000F8, 3'd3, 2'd0, 4'd9, 7'h20, 4'd2},  // R14 reserved I/O
        '{20'h02000, 3'd4, 2'd0, 4'd9, 7'h00, 4'd1},  // R5 lower ignores I/O
        '{20'hFC010, 3'd3, 2'd0, 4'd9, 7'h00, 4'd1},  // R5 upper ignores I/O
        '{20'h000F8, 3'd0, 2'd0, 4'd9, 7'h02, 4'd2},  // R6 I/O window ignores mem
        '{20'h02000, 3'd0, 2'd3, 4'd9, 7'h00, 4'd1},  // R7 reserved source
        '{20'h02000, 3'd5, 2'd0, 4'd9, 7'h00, 4'd1},  // R5 undefined type
        '{20'h80000, 3'd0, 2'd0, 4'd9, 7'h00, 4'd1},  // R8 above mid limit
        '{20'h7FFFF, 3'd0, 2'd0, 4'd9, 7'h04, 4'd3},  // R8 mid limit edge
        '{20'h03FFF, 3'd0, 2'd0, 4'd9, 7'h02, 4'd2},  // R8 lower limit edge
        '{20'h04000, 3'd0, 2'd0, 4'd9, 7'h00, 4'd1},  // R12 gap
        '{20'hFBFFF, 3'd0, 2'd0, 4'd9, 7'h00, 4'd1}   // R8 below upper base
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [9:0] lim, input logic [9:0] bas,
                          input logic io, input logic nr, input logic [1:0] ws);
        @(negedge clk);
        reg_addr  = idx;
        reg_wdata = {lim, bas, io, nr, ws};
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic run_cycle(input logic [19:0] addr, input logic [2:0] ct, input logic [1:0] src,
                             input int rdy_at, input logic [6:0] exp_sel, input int exp_lat,
                             input string tag);
        int done_t;
        done_t = 0;
        @(negedge clk);
        cyc_addr  = addr;
        cyc_type  = ct;
        cyc_src   = src;
        cyc_start = 1'b1;
        rdy       = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        for (int t = 1; t <= 20; t++) begin
            if (t > 1) @(negedge clk);
            rdy = (t >= rdy_at);
            #1;
            if (t == 1) check(sel_n == ~exp_sel, {tag, " select mask"}, 32'(sel_n), 32'(~exp_sel));
            if (cyc_done) begin
                done_t = t;
                break;
            end
        end
        check(done_t == exp_lat, {tag, " done latency"}, 32'(done_t), 32'(exp_lat));
        @(negedge clk);
        rdy = 1'b0;
        #1;
        check((&sel_n) && !cyc_done, {tag, " R9 release"}, {24'h0, cyc_done, sel_n}, 32'h7F);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(&sel_n, "R1 selects high", 32'(sel_n), 32'h7F);
        check(!cyc_done, "R1 done low", 32'(cyc_done), 0);
        reg_addr = 3'd0;
        #1;
        check(reg_rdata == 25'h1003FF7, "R1 upper reset register", reg_rdata, 32'h1003FF7);
        reg_addr = 3'd1;
        #1;
        check(reg_rdata == 25'h0, "R1 lower reset register", reg_rdata, 0);

        // R1 upper window decodes top granule after reset: 3 waits, ready needed
        run_cycle(20'hFFC00, 3'd0, 2'd0, 2, 7'h01, 4, "R1 upper reset decode");
        run_cycle(20'hFF000, 3'd0, 2'd0, 9, 7'h00, 1, "R1 below reset base");

        // Configure windows (R2)
        wr_reg(3'd0, 10'h000, 10'h3F0, 1'b0, 1'b0, 2'd0);
        wr_reg(3'd1, 10'h00F, 10'h000, 1'b0, 1'b0, 2'd1);
        wr_reg(3'd2, 10'h1FF, 10'h100, 1'b0, 1'b0, 2'd2);
        wr_reg(3'd3, 10'h180, 10'h180, 1'b0, 1'b0, 2'd3);
        wr_reg(3'd4, 10'h1F0, 10'h1F0, 1'b0, 1'b1, 2'd0);
        wr_reg(3'd5, 10'h000, 10'h000, 1'b1, 1'b0, 2'd1);
        reg_addr = 3'd4;
        #1;
        check(reg_rdata == {1'b1, 10'h1F0, 10'h1F0, 1'b0, 1'b1, 2'd0}, "R2 readback",
              reg_rdata, {1'b1, 10'h1F0, 10'h1F0, 1'b0, 1'b1, 2'd0});
        reg_addr = 3'd6;
        #1;
        check(reg_rdata[24] == 1'b0, "R3 untouched window disabled", reg_rdata, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            run_cycle(VECS[v].addr, VECS[v].ctype, VECS[v].src, int'(VECS[v].rdy_at),
                      VECS[v].exp_sel, int'(VECS[v].exp_lat), $sformatf("vec%0d", v));
        end

        // R3 read-first enable keeps reset fields (zero), overlaps lower
        @(negedge clk);
        reg_addr = 3'd6;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        #1;
        check(reg_rdata == 25'h1000000, "R3 read enables with zero fields", reg_rdata, 32'h1000000);
        run_cycle(20'h00010, 3'd0, 2'd0, 9, 7'h42, 2, "R3 read-enabled window selects");

        // R4 rewrite keeps enable
        wr_reg(3'd3, 10'h181, 10'h181, 1'b0, 1'b0, 2'd0);
        reg_addr = 3'd3;
        #1;
        check(reg_rdata == {1'b1, 10'h181, 10'h181, 4'h0}, "R4 enable survives rewrite",
              reg_rdata, {1'b1, 10'h181, 10'h181, 4'h0});
        run_cycle(20'h60010, 3'd0, 2'd0, 9, 7'h04, 3, "R4 moved window");

        // R13 start during a cycle is ignored
        begin
            int done_t;
            int extra;
            done_t = 0;
            extra  = 0;
            @(negedge clk);
            cyc_addr = 20'h40000; cyc_type = 3'd0; cyc_src = 2'd0; cyc_start = 1'b1;
            @(negedge clk);
            cyc_addr = 20'h02000;
            for (int t = 1; t <= 10; t++) begin
                if (t > 1) @(negedge clk);
                if (t == 2) cyc_start = 1'b0;
                #1;
                if (t == 2) check(sel_n == ~7'h04, "R13 select unchanged", 32'(sel_n), 32'(~7'h04));
                if (cyc_done) begin
                    done_t = t;
                    break;
                end
            end
            check(done_t == 3, "R13 original latency kept", 32'(done_t), 3);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                #1;
                if (!(&sel_n) || cyc_done) extra++;
            end
            check(extra == 0, "R13 no second cycle", 32'(extra), 0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule